// File: doc/BRIEF.md
# Watchdog Control and Timeout Interrupt Flag

This block is the control/status register that sits beside a watchdog counter. It holds the settings that the counter reads: interrupt enable, change enable, reset enable and a 4-bit prescaler select. It also holds the sticky flag that records a watchdog timeout. The prescaler select is split across the register, with its top bit away from the lower three. The block puts it back together as one 4-bit output for the counter.

The timeout flag sets on a timeout pulse from the counter, but only while interrupts are enabled in this register. The flag clears in two ways. The interrupt vectoring logic can pulse an acknowledge when the handler is entered. Software can also write a one to the flag bit. An interrupt request goes out only while the flag, the local interrupt enable and the global interrupt enable are all high.

The register port is a plain single-cycle write strobe plus a combinational read value. It has no valid/ready handshake: a write is always accepted in the cycle it is strobed, so no back-pressure exists. The timeout, acknowledge and global enable inputs are plain control pins.

Top module: `wdog_ctrl_status`

## Requirements
- R1: After reset, the register readback, the interrupt request and all control outputs are zero.
- R2: A write stores register bits 6:0 in the next cycle. The readback is laid out as bit 7 flag, bit 6 interrupt enable, bit 5 prescaler bit 3, bit 4 change enable, bit 3 reset enable, and bits 2:0 prescaler bits 2:0. Without a write, bits 6:0 hold their value.
- R3: The prescaler output equals {register bit 5, register bits 2:0}.
- R4: A timeout pulse while the stored interrupt enable is 1 sets the flag in the next cycle.
- R5: A timeout pulse while the stored interrupt enable is 0 leaves the flag unchanged.
- R6: An acknowledge pulse clears the flag in the next cycle.
- R7: A write with bit 7 at 1 clears the flag. A write with bit 7 at 0 leaves the flag unchanged.
- R8: When a flag-setting timeout and a clear (acknowledge or write-one) fall in the same cycle, the flag is 1 afterwards.
- R9: The interrupt request is high exactly when the flag, the stored interrupt enable and the global interrupt enable are all 1.
- R10: The interrupt-enable, change-enable and reset-enable outputs equal register bits 6, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback |
| tmo_pulse | input | 1 | Timeout pulse from the watchdog counter |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge pulse on vector entry |
| irq_req | output | 1 | Watchdog interrupt request |
| wd_irq_en | output | 1 | Stored interrupt enable |
| wd_chg_en | output | 1 | Stored change enable |
| wd_rst_en | output | 1 | Stored reset enable |
| wd_presc | output | 4 | Reassembled prescaler select |

## Verification
Directed patterns test the flag against each of its inputs on its own. These are a timeout with interrupts enabled and with them disabled, an acknowledge, and writes with bit 7 at one and at zero, so each path that sets or clears the flag is seen alone. Dedicated cycles then apply a timeout together with an acknowledge, and together with a write-one, to show that set wins over clear. Walking patterns written to the register separate the scattered prescaler bits from the neighbouring control bits. A long random mix of all inputs, with the global enable toggling, is compared every cycle against a behavioural model to cover the request gating.

// File: rtl/wdctl_pkg.sv
package wdctl_pkg;
  localparam int REG_W  = 8;
  localparam int PSC_W  = 4;
  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int P3_B   = 5;
  localparam int CE_B   = 4;
  localparam int RE_B   = 3;
  localparam int PLO_W  = 3;

  typedef struct packed {
    logic             ie;
    logic             ce;
    logic             re;
    logic [PSC_W-1:0] presc;
  } wd_ctrl_t;

  function automatic wd_ctrl_t unpack_ctrl(input logic [REG_W-1:0] v);
    wd_ctrl_t c;
    c.ie    = v[IE_B];
    c.ce    = v[CE_B];
    c.re    = v[RE_B];
    c.presc = {v[P3_B], v[PLO_W-1:0]};
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input logic flag, input wd_ctrl_t c);
    logic [REG_W-1:0] v;
    v             = '0;
    v[FLAG_B]     = flag;
    v[IE_B]       = c.ie;
    v[P3_B]       = c.presc[PSC_W-1];
    v[CE_B]       = c.ce;
    v[RE_B]       = c.re;
    v[PLO_W-1:0]  = c.presc[PLO_W-1:0];
    return v;
  endfunction
endpackage

// File: rtl/wdctl_ctrl.sv
module wdctl_ctrl
  import wdctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output wd_ctrl_t         ctrl_q
);
  wd_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = unpack_ctrl(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/wdctl_flag.sv
module wdctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo,
  input  logic irq_mode,
  input  logic ack,
  input  logic w1c,
  output logic flag_q
);
  logic set_c, clr_c, flag_d;

  always_comb begin
    set_c  = tmo & irq_mode;
    clr_c  = ack | w1c;
    flag_d = flag_q;
    if (clr_c) flag_d = 1'b0;
    if (set_c) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/wdog_ctrl_status.sv
module wdog_ctrl_status
  import wdctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             tmo_pulse,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             wd_irq_en,
  output logic             wd_chg_en,
  output logic             wd_rst_en,
  output logic [PSC_W-1:0] wd_presc
);
  wd_ctrl_t ctrl;
  logic     flag;

  wdctl_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .ctrl_q (ctrl)
  );

  wdctl_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmo      (tmo_pulse),
    .irq_mode (ctrl.ie),
    .ack      (irq_ack),
    .w1c      (cfg_we & cfg_wdata[FLAG_B]),
    .flag_q   (flag)
  );

  assign cfg_rdata = pack_reg(flag, ctrl);
  assign irq_req   = flag & ctrl.ie & gie;
  assign wd_irq_en = ctrl.ie;
  assign wd_chg_en = ctrl.ce;
  assign wd_rst_en = ctrl.re;
  assign wd_presc  = ctrl.presc;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       tmo_pulse,
  input logic       gie,
  input logic       irq_ack,
  input logic       irq_req,
  input logic       wd_irq_en,
  input logic       wd_chg_en,
  input logic       wd_rst_en,
  input logic [3:0] wd_presc
);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[6:0] == $past(cfg_wdata[6:0]));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata[6:0]));
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse && cfg_rdata[6]) |=> cfg_rdata[7]);
  p_noset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[7] && !(tmo_pulse && cfg_rdata[6])) |=> !cfg_rdata[7]);
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(tmo_pulse && cfg_rdata[6])) |=> !cfg_rdata[7]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[7] && !(tmo_pulse && cfg_rdata[6])) |=> !cfg_rdata[7]);
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (cfg_rdata[7] && wd_irq_en && gie));

  always_comb begin
    if (rst_n) begin
      a_presc_r3: assert (wd_presc == {cfg_rdata[5], cfg_rdata[2:0]});
      a_ctrl_r10: assert ({wd_irq_en, wd_chg_en, wd_rst_en} ==
                          {cfg_rdata[6], cfg_rdata[4], cfg_rdata[3]});
    end
  end
endmodule

bind wdog_ctrl_status wdog_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .tmo_pulse(tmo_pulse), .gie(gie), .irq_ack(irq_ack),
  .irq_req(irq_req), .wd_irq_en(wd_irq_en), .wd_chg_en(wd_chg_en),
  .wd_rst_en(wd_rst_en), .wd_presc(wd_presc)
);

// File: tb/tb_wdog_ctrl_status.sv
module tb_wdog_ctrl_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, tmo = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       irq, o_ie, o_ce, o_re;
  logic [3:0] o_ps;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  bit       m_flag = 0, m_ie = 0, m_ce = 0, m_re = 0;
  bit [3:0] m_ps = 0;

  always #5 clk = ~clk;

  wdog_ctrl_status dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd),
    .tmo_pulse(tmo), .gie(gie), .irq_ack(ack), .irq_req(irq),
    .wd_irq_en(o_ie), .wd_chg_en(o_ce), .wd_rst_en(o_re), .wd_presc(o_ps)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_ie = 0; m_ce = 0; m_re = 0; m_ps = 0;
    end else begin
      bit nf;
      nf = m_flag;
      if (ack || (we && wd[7])) nf = 0;
      if (tmo && m_ie) nf = 1;
      m_flag = nf;
      if (we) begin
        m_ie = wd[6]; m_ce = wd[4]; m_re = wd[3];
        m_ps = {wd[5], wd[2], wd[1], wd[0]};
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] exp_rd;
      exp_rd = {m_flag, m_ie, m_ps[3], m_ce, m_re, m_ps[2:0]};
      chk("readback", rd, exp_rd);
      chk("irq_req (R9)", {7'd0, irq}, {7'd0, m_flag & m_ie & gie});
      chk("ctrl outs (R10)", {5'd0, o_ie, o_ce, o_re}, {5'd0, m_ie, m_ce, m_re});
      chk("prescaler (R3)", {4'd0, o_ps}, {4'd0, m_ps});
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic step(input logic w, input logic [7:0] d, input logic t,
                      input logic g, input logic a);
    @(posedge clk); #1;
    we = w; wd = d; tmo = t; gie = g; ack = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, gie, 0);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    cur_req = "R2";
    step(1, 8'h7F, 0, 0, 0); idle(2);
    step(1, 8'h2A, 0, 0, 0); idle(2);
    step(1, 8'h15, 0, 0, 0); idle(2);
    cur_req = "R3";
    step(1, 8'h25, 0, 0, 0); idle(1);
    step(1, 8'h20, 0, 0, 0); idle(1);
    step(1, 8'h07, 0, 0, 0); idle(1);
    cur_req = "R10";
    step(1, 8'h58, 0, 0, 0); idle(1);
    cur_req = "R5";
    step(1, 8'h00, 0, 1, 0); step(0, 8'h00, 1, 1, 0); idle(2);
    cur_req = "R4";
    step(1, 8'h40, 0, 1, 0); step(0, 8'h00, 1, 1, 0); idle(2);
    cur_req = "R9";
    step(0, 8'h00, 0, 0, 0); idle(2);
    step(0, 8'h00, 0, 1, 0); idle(1);
    step(1, 8'h00, 0, 1, 0); idle(1);
    step(1, 8'h40, 0, 1, 0); idle(1);
    cur_req = "R6";
    step(0, 8'h00, 0, 1, 1); idle(2);
    cur_req = "R7";
    step(0, 8'h00, 1, 1, 0); idle(1);
    step(1, 8'h40, 0, 1, 0); idle(1);
    step(1, 8'hC0, 0, 1, 0); idle(2);
    cur_req = "R8";
    step(0, 8'h00, 1, 1, 0); idle(1);
    step(0, 8'h00, 1, 1, 1); idle(1);
    step(1, 8'hC0, 1, 1, 0); idle(1);
    step(1, 8'hC0, 1, 1, 1); idle(2);
    cur_req = "R9";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8], r[2], r[3] | r[4], r[5] & r[6]);
    end
    idle(3);
    finish_run();
  end
endmodule